// File: doc/BRIEF.md
# EPROM read and mode controller

This block is a synthesizable behavioural model of the control logic of a one-time-programmable 16-bit memory. It samples the active-low chip and output enables, a word/byte select, a programming-supply qualifier and a raised-voltage flag on the address bus. From these it picks the mode: read, output disable, standby, program, program verify, program inhibit, or identify. Analog levels are modelled as plain digital qualifier inputs.

The data port is split into a value bus and one output enable per byte lane, so a pad ring or bus model can turn it into a tri-state pin. In byte mode, bit 15 of the data input serves as the lowest address bit and picks which half of the word appears on the low lane. The storage is a small parameterised register file. It comes out of reset erased to all ones, and programming can only clear bits. Read data is released after a parameterised access delay counted in clock edges.

Top module: `eprom_ctl`

## Requirements
- R1: An edge that samples `ce_n` high releases both lanes (`dq_oe_lo` = `dq_oe_hi` = 0) after that edge, whatever `oe_n` is.
- R2: With `ce_n` low, an edge that samples `oe_n` high releases both lanes after that edge.
- R3: Lanes are driven only after ACC_CYC consecutive edges sample `ce_n` low with an unchanged access key (address, `id_en`, byte select, byte-address bit). Lanes are also driven only after OE_CYC consecutive edges sample `oe_n` low. A change of the key restarts the access count at 1.
- R4: In word mode the stored 16-bit word appears on `dq_out[15:0]`, with both lane enables high.
- R5: In byte mode (BYTE_CAPABLE=1, `byte_mode`=1, `prog_en`=0) `dq_oe_hi` stays 0 and `dq_out[15:8]` is 0. `dq_in[15]`=1 puts word bits 15..8 on `dq_out[7:0]`, and 0 puts bits 7..0 there.
- R6: With BYTE_CAPABLE=0, `byte_mode` and `dq_in[15]` have no effect on reads: whenever the low lane is driven, the high lane is driven too.
- R7: With `id_en`=1 and `addr[AW-1:1]`=0, a read returns 16'h00C2 for `addr[0]`=0. For `addr[0]`=1 it returns 16'h0112 when BYTE_CAPABLE=1 and 16'h0115 when BYTE_CAPABLE=0. Any other address under `id_en` returns 16'hFFFF.
- R8: After reset every location reads 16'hFFFF.
- R9: An edge with `prog_en`=1, `ce_n`=0, `oe_n`=1 and `id_en`=0 replaces the word at `addr` with its bitwise AND with `dq_in`. A 1 in `dq_in` never sets a cleared bit.
- R10: With `prog_en`=1, no write happens if `ce_n`=1 (inhibit) or `oe_n`=0 (verify, which reads like a normal access).
- R11: While `prog_en`=1 the block works in word mode even if `byte_mode`=1.
- R12: During reset and whenever a lane is released, its bits of `dq_out` are 0; `dq_oe_hi` is never 1 while `dq_oe_lo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, erases the array |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 selects byte-wide reads (byte-capable variant only) |
| prog_en | input | 1 | Programming supply present |
| id_en | input | 1 | Raised voltage flagged on the address line, selects identify codes |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data to program; bit 15 is the byte address in byte mode |
| dq_out | output | 16 | Registered read data |
| dq_oe_lo | output | 1 | Drive enable for bits 7..0 |
| dq_oe_hi | output | 1 | Drive enable for bits 15..8 |

## Verification
The checker watches the lane-enable rules on every cycle. It confirms the one-edge release on a high chip or output enable, the quiet high lane in byte mode, the paired lanes of the word-only variant, and the zero value on released lanes. Data values need the bench's scenarios: the exact edge at which data first appears after an address, chip-enable or output-enable change, the bit-clearing program behaviour and its inhibit and verify cases, the lane steering by the byte-address bit, and the identify codes of both variants.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int DW = 16;
  typedef logic [DW-1:0] word_t;

  localparam word_t MFR_CODE = 16'h00C2;

  function automatic word_t dev_code(input bit byte_capable);
    return byte_capable ? 16'h0112 : 16'h0115;
  endfunction
endpackage

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  word_t         wr_mask,
  output word_t         rd_data
);
  localparam int DEPTH = 1 << AW;

  word_t cells [DEPTH];

  // erase on reset, program by clearing bits only
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[addr] <= cells[addr] & wr_mask;
    end
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/eprom_timer.sv
module eprom_timer #(
  parameter int ACC_CYC = 3,
  parameter int OE_CYC  = 2,
  parameter int KW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [KW-1:0] key,
  output logic          ready_nx
);
  localparam int AC_W = $clog2(ACC_CYC + 1);
  localparam int OC_W = $clog2(OE_CYC + 1);
  localparam logic [AC_W-1:0] ACC_MAX = AC_W'(ACC_CYC);
  localparam logic [OC_W-1:0] OE_MAX  = OC_W'(OE_CYC);

  logic [AC_W-1:0] acc_cnt, acc_nx;
  logic [OC_W-1:0] oe_cnt, oe_nx;
  logic [KW-1:0]   key_q;

  always_comb begin
    if (ce_n)                acc_nx = '0;
    else if (key != key_q)   acc_nx = AC_W'(1);
    else if (acc_cnt != ACC_MAX) acc_nx = acc_cnt + 1'b1;
    else                     acc_nx = acc_cnt;

    if (oe_n)                oe_nx = '0;
    else if (oe_cnt != OE_MAX) oe_nx = oe_cnt + 1'b1;
    else                     oe_nx = oe_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt <= '0;
      oe_cnt  <= '0;
      key_q   <= '0;
    end else begin
      acc_cnt <= acc_nx;
      oe_cnt  <= oe_nx;
      key_q   <= key;
    end
  end

  assign ready_nx = (acc_nx == ACC_MAX) && (oe_nx == OE_MAX);
endmodule

// File: rtl/eprom_steer.sv
module eprom_steer
  import eprom_pkg::*;
(
  input  word_t word,
  input  logic  drive,
  input  logic  byte_sel,
  input  logic  upper,
  output word_t dq_nx,
  output logic  lo_nx,
  output logic  hi_nx
);
  always_comb begin
    dq_nx = '0;
    lo_nx = 1'b0;
    hi_nx = 1'b0;
    if (drive) begin
      lo_nx = 1'b1;
      if (byte_sel) begin
        dq_nx = {8'h00, (upper ? word[15:8] : word[7:0])};
      end else begin
        dq_nx = word;
        hi_nx = 1'b1;
      end
    end
  end
endmodule

// File: rtl/eprom_ctl.sv
module eprom_ctl
  import eprom_pkg::*;
#(
  parameter int AW           = 6,
  parameter bit BYTE_CAPABLE = 1'b1,
  parameter int ACC_CYC      = 3,
  parameter int OE_CYC       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          byte_mode,
  input  logic          prog_en,
  input  logic          id_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic          dq_oe_lo,
  output logic          dq_oe_hi
);
  localparam int KW = AW + 3;

  logic          byte_sel, upper, id_hit, wr_en, ready_nx, drive;
  logic          lo_nx, hi_nx;
  word_t         rd_data, id_word, src_word, dq_nx;
  logic [KW-1:0] key;

  // programming supply shares the byte-select function: it forces word mode
  assign byte_sel = BYTE_CAPABLE && byte_mode && !prog_en;
  assign upper    = byte_sel && dq_in[15];
  assign id_hit   = (addr[AW-1:1] == '0);
  assign id_word  = !id_hit ? '1 : (addr[0] ? dev_code(BYTE_CAPABLE) : MFR_CODE);
  assign src_word = id_en ? id_word : rd_data;
  assign wr_en    = prog_en && !ce_n && oe_n && !id_en;
  assign key      = {id_en, byte_sel, upper, addr};
  assign drive    = ready_nx && !ce_n && !oe_n;

  eprom_array #(.AW(AW)) u_array (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_mask (dq_in),
    .rd_data (rd_data)
  );

  eprom_timer #(.ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC), .KW(KW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .key      (key),
    .ready_nx (ready_nx)
  );

  eprom_steer u_steer (
    .word     (src_word),
    .drive    (drive),
    .byte_sel (byte_sel),
    .upper    (upper),
    .dq_nx    (dq_nx),
    .lo_nx    (lo_nx),
    .hi_nx    (hi_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out   <= '0;
      dq_oe_lo <= 1'b0;
      dq_oe_hi <= 1'b0;
    end else begin
      dq_out   <= dq_nx;
      dq_oe_lo <= lo_nx;
      dq_oe_hi <= hi_nx;
    end
  end
endmodule

// File: rtl/eprom_ctl_chk.sv
module eprom_ctl_chk #(
  parameter bit BYTE_CAPABLE = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        ce_n,
  input logic        oe_n,
  input logic        byte_mode,
  input logic        prog_en,
  input logic [15:0] dq_out,
  input logic        dq_oe_lo,
  input logic        dq_oe_hi
);
  // R1
  ce_float_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!dq_oe_lo && !dq_oe_hi));

  // R2
  oe_float_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!dq_oe_lo && !dq_oe_hi));

  // R5
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (BYTE_CAPABLE && byte_mode && !prog_en) |=> !dq_oe_hi);

  // R6
  wide_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!BYTE_CAPABLE && dq_oe_lo) |-> dq_oe_hi);

  // R12
  lane_pair_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe_hi |-> dq_oe_lo);

  // R12
  quiet_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_oe_lo |-> (dq_out == 16'h0000));

  // R12
  quiet_hi_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_oe_hi |-> (dq_out[15:8] == 8'h00));
endmodule

bind eprom_ctl eprom_ctl_chk #(.BYTE_CAPABLE(BYTE_CAPABLE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .byte_mode (byte_mode),
  .prog_en   (prog_en),
  .dq_out    (dq_out),
  .dq_oe_lo  (dq_oe_lo),
  .dq_oe_hi  (dq_oe_hi)
);

// File: tb/sim_eprom_ctl.sv
module sim_eprom_ctl;
  localparam int AW  = 6;
  localparam int ACC = 3;
  localparam int OEC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0, prog_en = 1'b0, id_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq0, dq1;
  logic          lo0, hi0, lo1, hi1;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  eprom_ctl #(.AW(AW), .BYTE_CAPABLE(1'b1), .ACC_CYC(ACC), .OE_CYC(OEC)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode),
    .prog_en(prog_en), .id_en(id_en), .addr(addr), .dq_in(dq_in),
    .dq_out(dq0), .dq_oe_lo(lo0), .dq_oe_hi(hi0));

  eprom_ctl #(.AW(AW), .BYTE_CAPABLE(1'b0), .ACC_CYC(ACC), .OE_CYC(OEC)) u1 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .byte_mode(byte_mode),
    .prog_en(prog_en), .id_en(id_en), .addr(addr), .dq_in(dq_in),
    .dq_out(dq1), .dq_oe_lo(lo1), .dq_oe_hi(hi1));

  // {byte_mode, dq_in[15], id_en, addr, u0 data, u0 hi lane, u1 data}
  localparam logic [41:0] VEC [12] = '{
    {1'b0, 1'b0, 1'b0, 6'd5,  16'hA53C, 1'b1, 16'hA53C},
    {1'b1, 1'b0, 1'b0, 6'd5,  16'h003C, 1'b0, 16'hA53C},
    {1'b1, 1'b1, 1'b0, 6'd5,  16'h00A5, 1'b0, 16'hA53C},
    {1'b0, 1'b0, 1'b0, 6'd0,  16'hFFFF, 1'b1, 16'hFFFF},
    {1'b0, 1'b0, 1'b1, 6'd0,  16'h00C2, 1'b1, 16'h00C2},
    {1'b0, 1'b0, 1'b1, 6'd1,  16'h0112, 1'b1, 16'h0115},
    {1'b0, 1'b0, 1'b1, 6'd3,  16'hFFFF, 1'b1, 16'hFFFF},
    {1'b1, 1'b0, 1'b1, 6'd1,  16'h0012, 1'b0, 16'h0115},
    {1'b1, 1'b1, 1'b1, 6'd0,  16'h0000, 1'b0, 16'h00C2},
    {1'b0, 1'b0, 1'b0, 6'd9,  16'h1234, 1'b1, 16'h1234},
    {1'b1, 1'b1, 1'b0, 6'd9,  16'h0012, 1'b0, 16'h1234},
    {1'b0, 1'b0, 1'b1, 6'd33, 16'hFFFF, 1'b1, 16'hFFFF}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    step(3);
    // R12 reset state
    chk("R12 reset u0", {hi0, lo0, dq0}, 18'h0);
    chk("R12 reset u1", {hi1, lo1, dq1}, 18'h0);
    rst = 1'b0;
    step(1);

    // R8 erased reads
    ce_n = 1'b0; oe_n = 1'b0; addr = 6'd0;
    step(ACC);
    chk("R8 erased addr0", {hi0, lo0, dq0}, {2'b11, 16'hFFFF});
    addr = 6'd63;
    step(ACC);
    chk("R8 erased addr63", {hi0, lo0, dq0}, {2'b11, 16'hFFFF});

    // R9 program: clears only
    oe_n = 1'b1; prog_en = 1'b1; addr = 6'd5; dq_in = 16'hA53C;
    step(1);
    addr = 6'd9; dq_in = 16'h1274;
    step(1);
    dq_in = 16'hFFBF;
    step(1);
    ce_n = 1'b1;
    step(1);

    // R10 inhibit with chip enable high
    addr = 6'd7; dq_in = 16'h0000;
    step(2);
    // R10 verify does not write; R11 supply forces word mode
    ce_n = 1'b0; oe_n = 1'b0; byte_mode = 1'b1;
    step(ACC);
    chk("R10 R11 verify addr7", {hi0, lo0, dq0}, {2'b11, 16'hFFFF});
    ce_n = 1'b1; prog_en = 1'b0; byte_mode = 1'b0;
    step(1);

    // table walk: R4 R5 R6 R7 R9
    for (int i = 0; i < 12; i++) begin
      byte_mode = VEC[i][41];
      dq_in     = {VEC[i][40], 15'h0};
      id_en     = VEC[i][39];
      addr      = VEC[i][38:33];
      ce_n = 1'b0; oe_n = 1'b0;
      step(ACC);
      chk("R4 R5 R7 R9 u0 vector", {hi0, lo0, dq0}, {VEC[i][16], 1'b1, VEC[i][32:17]});
      chk("R6 R7 u1 vector", {hi1, lo1, dq1}, {2'b11, VEC[i][15:0]});
    end

    // R3 chip-enable access latency
    ce_n = 1'b1; byte_mode = 1'b0; id_en = 1'b0; dq_in = '0; addr = 6'd5;
    step(2);
    ce_n = 1'b0; oe_n = 1'b0;
    step(ACC - 1);
    chk("R3 before access time", {hi0, lo0}, 18'h0);
    step(1);
    chk("R3 at access time", {hi0, lo0, dq0}, {2'b11, 16'hA53C});
    // R2 release on output enable
    oe_n = 1'b1;
    step(1);
    chk("R2 oe release", {hi0, lo0, dq0}, 18'h0);
    // R3 output-enable latency
    oe_n = 1'b0;
    step(OEC - 1);
    chk("R3 before oe time", {hi0, lo0}, 18'h0);
    step(1);
    chk("R3 at oe time", {hi0, lo0, dq0}, {2'b11, 16'hA53C});
    // R1 release on chip enable with oe low
    ce_n = 1'b1;
    step(1);
    chk("R1 ce release", {hi1, lo1, hi0, lo0}, 18'h0);
    step(3);
    chk("R1 standby holds", {hi0, lo0, dq0}, 18'h0);

    // R5 byte-address change restarts access
    ce_n = 1'b0; byte_mode = 1'b1; dq_in = 16'h0000;
    step(ACC);
    chk("R5 low byte", {hi0, lo0, dq0}, {2'b01, 16'h003C});
    dq_in = 16'h8000;
    step(1);
    chk("R5 restart on byte address", {hi0, lo0}, 18'h0);
    chk("R6 u1 ignores byte address", {hi1, lo1, dq1}, {2'b11, 16'hA53C});
    step(ACC - 1);
    chk("R5 high byte", {hi0, lo0, dq0}, {2'b01, 16'h00A5});

    report();
  end
endmodule